// File: doc/BRIEF.md
# I2C Combined-Format Register Reader

This block reads one 8-bit register from an I2C target. It uses the combined transfer format. A pulse on `go` starts the sequence and captures a 7-bit device address and an 8-bit register address. A command sequencer then drives a byte-level bus engine in four steps:

1. A write-addressed frame that carries the register index.
2. A repeated start.
3. A read-addressed frame.
4. A single received byte, closed with a not-acknowledge and a stop.

When the sequence ends, the block pulses `done`. The byte is presented on `rd_data` in the same cycle. If the target refuses any address byte, the sequence closes the bus with a stop and reports `err`.

The sequencer works in per-byte commands. Each command carries start, stop, read, write and acknowledge-control bits. After issuing a command, the sequencer waits until the engine reports that the transfer has finished. After a write, it also inspects the acknowledge bit the target returned. The engine builds every bit from four quarter periods of `QTR_CYC` clocks each. It drives the bus in open-drain form: an output enable at 1 pulls the line low.

Top module: `regrd_ctrl`

## Requirements
- R1: After synchronous reset, `scl_oe` and `sda_oe` are 0 (both lines released; 1 means pull low), `done` is 0 and `err` is 0.
- R2: An accepted `go` produces a start condition followed by the byte `{dev_addr, 1'b0}`, sent most significant bit first.
- R3: Once the target acknowledges the first byte, the register address byte follows with no start or stop condition between the two frames.
- R4: Once the register byte is acknowledged, a repeated start is issued, followed by `{dev_addr, 1'b1}`; the least significant bit appears high on SDA.
- R5: After the read address is acknowledged, the block clocks in one byte most significant bit first, leaves SDA released (not-acknowledge) on the ninth clock pulse, then produces a stop condition and releases both lines.
- R6: A successful sequence ends with `done` high for exactly one cycle, `err` at 0, and `rd_data` equal to the byte the target sent.
- R7: If the acknowledge bit of any of the three address-phase bytes is high, no further byte is sent. A stop condition follows, and `done` pulses with `err` at 1.
- R8: A `go` pulse that arrives while a sequence is running has no effect on the bus traffic or on the number of `done` pulses.
- R9: Every byte frame contains exactly nine SCL high pulses. SDA changes while SCL is high only for start and stop conditions. No command reaches the engine while it is busy.
- R10: `err` keeps its value after `done` until the next accepted `go`, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | Start pulse; ignored while busy |
| dev_addr | input | 7 | Target device address, captured on accepted `go` |
| reg_addr | input | 8 | Register index, captured on accepted `go` |
| rd_data | output | 8 | Byte read; valid when `done` is high and `err` is low |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Target refused an address byte; held until the next accepted `go` |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| sda_in | input | 1 | Resolved SDA level |

## Verification
The hardest case to reach is a refusal on the third frame, the read-addressed byte after the repeated start. The target must accept the first two frames and reject only the read direction, so the simple approach of using a wrong device address cannot produce it. The bench therefore uses a bit-level target model that can be told which phase to refuse. The bench also injects a second `go` with a different address midway through a full read, and checks that the scoreboard's bus-event queue and the single `done` are unchanged.

// File: rtl/regrd_pkg.sv
package regrd_pkg;

    localparam int DEV_W  = 7;
    localparam int BYTE_W = 8;
    localparam int FRAME_BITS = BYTE_W + 1;

    typedef struct packed {
        logic sta;
        logic sto;
        logic rd;
        logic wr;
        logic nack;
    } eng_cmd_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_DEVW,
        SQ_REGA,
        SQ_DEVR,
        SQ_DATA,
        SQ_ABORT
    } seq_state_t;

    typedef enum logic [1:0] {
        EP_IDLE,
        EP_START,
        EP_BIT,
        EP_STOP
    } eng_phase_t;

    function automatic logic [BYTE_W-1:0] addr_byte(input logic [DEV_W-1:0] dev,
                                                    input logic rw);
        return {dev, rw};
    endfunction

    function automatic eng_cmd_t mk_cmd(input logic sta, input logic sto,
                                        input logic rd, input logic wr,
                                        input logic nack);
        eng_cmd_t c;
        c.sta  = sta;
        c.sto  = sto;
        c.rd   = rd;
        c.wr   = wr;
        c.nack = nack;
        return c;
    endfunction

endpackage

// File: rtl/regrd_byte_eng.sv
module regrd_byte_eng
    import regrd_pkg::*;
#(
    parameter int QTR_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_stb,
    input  eng_cmd_t          cmd,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tip,
    output logic              rx_ack,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);

    localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
    localparam int BW = $clog2(FRAME_BITS + 1);
    localparam logic [BW-1:0] ACK_IDX = BW'(BYTE_W);

    eng_phase_t        phase;
    eng_cmd_t          cmd_q;
    logic [1:0]        qtr;
    logic [CW-1:0]     div_cnt;
    logic [BW-1:0]     bit_idx;
    logic [BYTE_W-1:0] sh;
    logic              scl_hold;
    logic              tip_q;
    logic              rx_ack_q;
    logic              tick;
    logic              qend;
    logic              bitval;

    assign tick = (phase != EP_IDLE) && (div_cnt == CW'(QTR_CYC - 1));
    assign qend = tick && (qtr == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= EP_IDLE;
            cmd_q    <= '0;
            qtr      <= '0;
            div_cnt  <= '0;
            bit_idx  <= '0;
            sh       <= '0;
            scl_hold <= 1'b0;
            tip_q    <= 1'b0;
            rx_ack_q <= 1'b0;
        end else if (phase == EP_IDLE) begin
            div_cnt <= '0;
            qtr     <= '0;
            if (cmd_stb) begin
                cmd_q   <= cmd;
                sh      <= cmd.wr ? tx_byte : '0;
                bit_idx <= '0;
                tip_q   <= cmd.sta | cmd.sto | cmd.rd | cmd.wr;
                if (cmd.sta)               phase <= EP_START;
                else if (cmd.rd | cmd.wr)  phase <= EP_BIT;
                else if (cmd.sto)          phase <= EP_STOP;
            end
        end else begin
            div_cnt <= tick ? '0 : div_cnt + 1'b1;
            if (tick) qtr <= qtr + 1'b1;
            // sample point: SCL has been high for one quarter
            if (tick && qtr == 2'd1 && phase == EP_BIT) begin
                if (bit_idx < ACK_IDX) begin
                    if (cmd_q.rd) sh <= {sh[BYTE_W-2:0], sda_in};
                end else if (cmd_q.wr) begin
                    rx_ack_q <= sda_in;
                end
            end
            if (qend) begin
                unique case (phase)
                    EP_START: begin
                        scl_hold <= 1'b1;
                        bit_idx  <= '0;
                        if (cmd_q.rd | cmd_q.wr) phase <= EP_BIT;
                        else if (cmd_q.sto)      phase <= EP_STOP;
                        else begin
                            phase <= EP_IDLE;
                            tip_q <= 1'b0;
                        end
                    end
                    EP_BIT: begin
                        if (bit_idx == ACK_IDX) begin
                            if (cmd_q.sto) phase <= EP_STOP;
                            else begin
                                phase <= EP_IDLE;
                                tip_q <= 1'b0;
                            end
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            if (cmd_q.wr) sh <= {sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                    EP_STOP: begin
                        phase    <= EP_IDLE;
                        tip_q    <= 1'b0;
                        scl_hold <= 1'b0;
                    end
                    default: phase <= EP_IDLE;
                endcase
            end
        end
    end

    // level the master puts on SDA during a data or acknowledge bit
    always_comb begin
        if (bit_idx < ACK_IDX) bitval = cmd_q.wr ? sh[BYTE_W-1] : 1'b1;
        else                   bitval = cmd_q.rd ? cmd_q.nack : 1'b1;
    end

    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (phase)
            EP_IDLE:  scl_oe = scl_hold;
            EP_START: begin
                scl_oe = (qtr == 2'd0) || (qtr == 2'd3);
                sda_oe = (qtr == 2'd2) || (qtr == 2'd3);
            end
            EP_BIT: begin
                scl_oe = (qtr == 2'd0) || (qtr == 2'd3);
                sda_oe = ~bitval;
            end
            EP_STOP: begin
                scl_oe = (qtr == 2'd0);
                sda_oe = (qtr == 2'd0) || (qtr == 2'd1);
            end
            default: ;
        endcase
    end

    assign tip     = tip_q;
    assign rx_ack  = rx_ack_q;
    assign rx_byte = sh;

    // inside a bit, SDA must not move while SCL is high
    assert_sda_stable_scl_high_R9: assert property (@(posedge clk) disable iff (rst)
        (!scl_oe && !$past(scl_oe) && phase == EP_BIT && $past(phase) == EP_BIT)
            |-> $stable(sda_oe));

    assert_cmd_starts_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_stb && (cmd.sta || cmd.sto || cmd.rd || cmd.wr)) |=> tip);

endmodule

// File: rtl/regrd_seq.sv
module regrd_seq
    import regrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [BYTE_W-1:0] reg_addr,
    input  logic              tip,
    input  logic              rx_ack,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              cmd_stb,
    output eng_cmd_t          cmd,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [BYTE_W-1:0] rd_data,
    output logic              done,
    output logic              err
);

    seq_state_t        st;
    logic [DEV_W-1:0]  dev_q;
    logic [BYTE_W-1:0] reg_q;
    logic              step_done;

    // a step is over once the strobe has been taken and the engine is idle again
    assign step_done = (st != SQ_IDLE) && !cmd_stb && !tip;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            dev_q   <= '0;
            reg_q   <= '0;
            cmd_stb <= 1'b0;
            cmd     <= '0;
            tx_byte <= '0;
            rd_data <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            cmd_stb <= 1'b0;
            done    <= 1'b0;
            unique case (st)
                SQ_IDLE: if (go) begin
                    dev_q   <= dev_addr;
                    reg_q   <= reg_addr;
                    err     <= 1'b0;
                    cmd_stb <= 1'b1;
                    cmd     <= mk_cmd(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
                    tx_byte <= addr_byte(dev_addr, 1'b0);
                    st      <= SQ_DEVW;
                end
                SQ_DEVW, SQ_REGA, SQ_DEVR: if (step_done) begin
                    cmd_stb <= 1'b1;
                    if (rx_ack) begin
                        cmd <= mk_cmd(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
                        st  <= SQ_ABORT;
                    end else if (st == SQ_DEVW) begin
                        cmd     <= mk_cmd(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
                        tx_byte <= reg_q;
                        st      <= SQ_REGA;
                    end else if (st == SQ_REGA) begin
                        cmd     <= mk_cmd(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
                        tx_byte <= addr_byte(dev_q, 1'b1);
                        st      <= SQ_DEVR;
                    end else begin
                        cmd <= mk_cmd(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
                        st  <= SQ_DATA;
                    end
                end
                SQ_DATA: if (step_done) begin
                    rd_data <= rx_byte;
                    done    <= 1'b1;
                    st      <= SQ_IDLE;
                end
                SQ_ABORT: if (step_done) begin
                    err  <= 1'b1;
                    done <= 1'b1;
                    st   <= SQ_IDLE;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    assert_no_cmd_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_stb |-> !tip);

    assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_go_ignored_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (st != SQ_IDLE) |=> $stable(dev_q));

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);

    assert_first_cmd_start_write_R2: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && go) |=> (cmd_stb && cmd.sta && cmd.wr && !tx_byte[0]));

endmodule

// File: rtl/regrd_ctrl.sv
module regrd_ctrl
    import regrd_pkg::*;
#(
    parameter int QTR_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [DEV_W-1:0]  dev_addr,
    input  logic [BYTE_W-1:0] reg_addr,
    output logic [BYTE_W-1:0] rd_data,
    output logic              done,
    output logic              err,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);

    logic              cmd_stb;
    eng_cmd_t          cmd;
    logic [BYTE_W-1:0] tx_byte;
    logic              tip;
    logic              rx_ack;
    logic [BYTE_W-1:0] rx_byte;

    regrd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .dev_addr (dev_addr),
        .reg_addr (reg_addr),
        .tip      (tip),
        .rx_ack   (rx_ack),
        .rx_byte  (rx_byte),
        .cmd_stb  (cmd_stb),
        .cmd      (cmd),
        .tx_byte  (tx_byte),
        .rd_data  (rd_data),
        .done     (done),
        .err      (err)
    );

    regrd_byte_eng #(.QTR_CYC(QTR_CYC)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .cmd_stb  (cmd_stb),
        .cmd      (cmd),
        .tx_byte  (tx_byte),
        .tip      (tip),
        .rx_ack   (rx_ack),
        .rx_byte  (rx_byte),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .sda_in   (sda_in)
    );

endmodule

// File: tb/regrd_ctrl_bench.sv
module regrd_ctrl_bench;

    localparam logic [6:0] TGT = 7'h5A;
    localparam int EV_S = 1000, EV_P = 2000, EV_MACK = 4000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       go  = 1'b0;
    logic [6:0] dev_addr = '0;
    logic [7:0] reg_addr = '0;
    logic [7:0] rd_data;
    logic       done, err, scl_oe, sda_oe, sda_in;
    logic       t_drv = 1'b0;

    assign sda_in = ~sda_oe & ~t_drv;

    always #4 clk = ~clk;

    regrd_ctrl u_regrd_ctrl (
        .clk(clk), .rst(rst), .go(go), .dev_addr(dev_addr), .reg_addr(reg_addr),
        .rd_data(rd_data), .done(done), .err(err),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    int checks = 0, errors = 0, done_cnt = 0, nack_ph = 0, cyc = 0;
    int exp_ev[$];
    int exp_res[$];

    function automatic logic [7:0] tdata(input logic [7:0] r);
        return r ^ 8'h5C;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic note_event(input int ev);
        int e;
        if (exp_ev.size() == 0) chk(1'b0, "R8 R9 unexpected bus event", ev, -1);
        else begin
            e = exp_ev.pop_front();
            chk(ev == e, "bus sequence R2 R3 R4 R5 R7", ev, e);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // bit-level target model: mode 0 idle, 1 address, 2 register, 3 read
    logic pscl = 1'b1, psda = 1'b1, scl_b, sda_b, mack;
    logic [7:0] rxb = '0, rdat = '0;
    int tmode = 0, nxt = 0, bitn = 0, pulses = 0;
    bit ok;

    always @(negedge clk) begin
        scl_b = ~scl_oe;
        sda_b = sda_in;
        if (pscl && scl_b && psda && !sda_b) begin
            note_event(EV_S);
            tmode = 1; bitn = 0; pulses = 0; rxb = '0; t_drv = 1'b0;
        end else if (pscl && scl_b && !psda && sda_b) begin
            note_event(EV_P);
            tmode = 0; t_drv = 1'b0;
        end else if (!pscl && scl_b) begin
            pulses++;
            if (tmode == 1 || tmode == 2) begin
                if (bitn < 8) rxb = {rxb[6:0], sda_b};
                bitn++;
            end else if (tmode == 3) begin
                if (bitn < 8) bitn++;
                else if (bitn == 8) begin
                    mack = sda_b;
                    note_event(rdat);
                    note_event(EV_MACK + mack);
                    bitn = 9;
                end
            end
        end else if (pscl && !scl_b) begin
            if (tmode == 1 || tmode == 2) begin
                if (bitn == 8) begin
                    note_event(rxb);
                    if (tmode == 1) begin
                        ok  = (rxb[7:1] == TGT) && !(rxb[0] == 1'b0 && nack_ph == 1)
                                                && !(rxb[0] == 1'b1 && nack_ph == 3);
                        nxt = ok ? (rxb[0] ? 3 : 2) : 0;
                    end else begin
                        ok   = (nack_ph != 2);
                        rdat = tdata(rxb);
                        nxt  = 0;
                    end
                    t_drv = ok;
                end else if (bitn == 9) begin
                    t_drv = 1'b0;
                    chk(pulses == 9, "R9 nine clock pulses per frame", pulses, 9);
                    pulses = 0; bitn = 0; tmode = nxt;
                    if (tmode == 3) t_drv = ~rdat[7];
                end
            end else if (tmode == 3) begin
                if (bitn >= 1 && bitn <= 7) t_drv = ~rdat[7 - bitn];
                else if (bitn == 8) t_drv = 1'b0;
                else if (bitn == 9) begin
                    t_drv = 1'b0;
                    chk(pulses == 9, "R9 nine clock pulses in read frame", pulses, 9);
                    pulses = 0; bitn = 0; tmode = 0;
                end
            end
        end
        pscl = scl_b;
        psda = sda_b;
    end

    // monitor: pops expected results as the design completes
    logic pdone = 1'b0;
    always @(negedge clk) begin
        int e;
        if (!rst) begin
            if (done && pdone) chk(1'b0, "R6 done wider than one cycle", 1, 0);
            if (done) begin
                done_cnt++;
                if (exp_res.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
                else begin
                    e = exp_res.pop_front();
                    chk(err == e[8], "R7 R6 err at done", err, e[8]);
                    if (!e[8]) chk(rd_data == e[7:0], "R5 R6 read data", rd_data, e[7:0]);
                end
            end
        end
        pdone = done;
    end

    // driver: pushes expected bus events and result, then starts the sequence
    task automatic run_read(input logic [6:0] dev, input logic [7:0] ra,
                            input int nph, input bit noise);
        int c0;
        int res;
        nack_ph = nph;
        exp_ev.push_back(EV_S);
        exp_ev.push_back({dev, 1'b0});
        if (nph == 1 || dev != TGT) begin
            exp_ev.push_back(EV_P); res = 256;
        end else begin
            exp_ev.push_back(ra);
            if (nph == 2) begin
                exp_ev.push_back(EV_P); res = 256;
            end else begin
                exp_ev.push_back(EV_S);
                exp_ev.push_back({dev, 1'b1});
                if (nph == 3) begin
                    exp_ev.push_back(EV_P); res = 256;
                end else begin
                    exp_ev.push_back(tdata(ra));
                    exp_ev.push_back(EV_MACK + 1);
                    exp_ev.push_back(EV_P);
                    res = tdata(ra);
                end
            end
        end
        exp_res.push_back(res);
        c0 = done_cnt;
        @(negedge clk);
        dev_addr = dev; reg_addr = ra; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        chk(err == 1'b0, "R10 err cleared by accepted go", err, 0);
        if (noise) begin
            repeat (300) @(negedge clk);
            dev_addr = 7'h11; reg_addr = 8'hEE; go = 1'b1;
            @(negedge clk);
            go = 1'b0;
        end
        for (int i = 0; i < 20000 && done_cnt == c0; i++) @(negedge clk);
        repeat (60) @(negedge clk);
        chk(done_cnt == c0 + 1, "R8 exactly one done per sequence", done_cnt - c0, 1);
        chk(!scl_oe && !sda_oe, "R5 R7 bus released after stop", {scl_oe, sda_oe}, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual %0d expected done", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R1 lines released after reset", {scl_oe, sda_oe}, 0);
        chk(!done && !err, "R1 done and err low after reset", {done, err}, 0);
        run_read(TGT, 8'hA3, 0, 1'b0);   // R2 R3 R4 R5 R6
        run_read(TGT, 8'h5C, 0, 1'b1);   // data 00, stray go mid-run: R8
        run_read(TGT, 8'hFF, 0, 1'b0);
        run_read(TGT, 8'h00, 1, 1'b0);   // R7 refusal of first frame
        chk(err == 1'b1, "R10 err held after abort", err, 1);
        run_read(TGT, 8'h3C, 2, 1'b0);   // R7 refusal of register byte
        run_read(TGT, 8'h81, 3, 1'b0);   // R7 refusal after repeated start
        run_read(7'h11, 8'h12, 0, 1'b0); // R7 absent device
        run_read(TGT, 8'h7E, 0, 1'b1);   // R10 clear then success, R8 noise
        chk(err == 1'b0, "R10 err low after successful read", err, 0);
        repeat (200) @(negedge clk);
        chk(exp_ev.size() == 0, "R7 all expected bus events seen", exp_ev.size(), 0);
        chk(exp_res.size() == 0, "R6 all expected results seen", exp_res.size(), 0);
        finish_run();
    end

endmodule